// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is a per-core countdown timer that software drives through a small register port. The port has a write strobe, a read strobe, an address and 64-bit data. Software writes a configuration word that holds a run bit, a repeat bit and a start count. The timer then counts down by one on every clock. When the count reaches zero the block records a sticky pending event. In repeat mode it refills the count and keeps going. In single-shot mode it parks the count at the 48-bit all-ones value and stays idle.

The pending event reaches the interrupt pin only while a separate mask bit is set. Software acknowledges the event through a dedicated write-one-to-clear register. It can read the event back as bit 11 of a read-only status word. A free-running 64-bit counter advances on every clock whatever the timer is doing, so software can always take a timestamp.

Reads return their data in the same cycle the read strobe is high, through a combinational path. Writes take effect at the clock edge that samples the strobe.

Top module: `ctimer_top`

## Requirements
- R1: After reset the configuration, live count, status, mask and pending event are all zero, and the interrupt pin is low.
- R2: A configuration write stores data bits [47:0] (bit 0 = run, bit 1 = repeat, bits [47:2] = start count), and reading it back returns exactly those bits with bits [63:48] zero. If the run bit is set, the live count becomes the start count times four at that same edge.
- R3: While running, the live count drops by exactly one per clock until it reaches zero.
- R4: The cycle in which a running count reads zero is the expiry cycle. The pending event is set at the edge that ends that cycle, so it is first visible one cycle after the zero.
- R5: In repeat mode an expiry refills the count from the configured start count and the timer keeps running, so events recur every start count times four plus one cycles.
- R6: In single-shot mode an expiry sets the count to 2^48-1 and halts it, and no further event occurs.
- R7: A configuration write with the run bit clear halts the timer. The count holds its value and no expiry follows.
- R8: Writing the clear register (address 0x44) with data bit 0 = 1 clears the pending event, and bit 0 = 0 has no effect. If a clear and an expiry coincide, the event stays set.
- R9: The interrupt pin is high exactly when the pending event is set and bit 11 of the mask register (address 0x04) is set.
- R10: The status register (address 0x05) reads the pending event at bit 11 and ignores writes. Reads of the clear register or of any unmapped address return zero. Writes to unmapped addresses change nothing.
- R11: The stamp counter (address 0x48) increases by exactly one per clock, independent of the timer state.
- R12: The register map is: configuration 0x41, live count 0x42, clear 0x44, mask 0x04, status 0x05, stamp 0x48. The live count reads zero-extended and the mask reads back bit 11 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 14 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid while reg_rd is high, zero otherwise |
| timer_irq | output | 1 | Masked timer interrupt |

## Verification
The embedded properties check the cycle-level rules on every clock:
- the one-per-clock decrement;
- refill on a repeat expiry and park on a single-shot expiry;
- holding the count while halted;
- the set and clear behaviour of the pending event;
- the interrupt gating;
- the steady advance of the stamp counter.

Only the bench scenarios can show the rest. These cover the exact expiry latency measured from a configuration write, the repeat period seen through software reads, and that a clear coinciding with an expiry leaves the event set. They also cover that writes to read-only or unmapped addresses leave every readable register untouched.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  localparam int unsigned DATA_W_DEF  = 64;
  localparam int unsigned ADDR_W_DEF  = 14;
  localparam int unsigned CNT_W_DEF   = 48;
  localparam int unsigned IRQ_BIT_DEF = 11;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_LIVE,
    SEL_ACK,
    SEL_MASK,
    SEL_STAT,
    SEL_STAMP
  } reg_sel_e;
endpackage

// File: rtl/ctimer_decode.sv
module ctimer_decode
  import ctimer_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] A_CFG   = 14'h041,
  parameter logic [ADDR_W-1:0] A_LIVE  = 14'h042,
  parameter logic [ADDR_W-1:0] A_ACK   = 14'h044,
  parameter logic [ADDR_W-1:0] A_MASK  = 14'h004,
  parameter logic [ADDR_W-1:0] A_STAT  = 14'h005,
  parameter logic [ADDR_W-1:0] A_STAMP = 14'h048
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if      (addr == A_CFG)   sel = SEL_CFG;
    else if (addr == A_LIVE)  sel = SEL_LIVE;
    else if (addr == A_ACK)   sel = SEL_ACK;
    else if (addr == A_MASK)  sel = SEL_MASK;
    else if (addr == A_STAT)  sel = SEL_STAT;
    else if (addr == A_STAMP) sel = SEL_STAMP;
  end
endmodule

// File: rtl/ctimer_down.sv
module ctimer_down #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_wval,
  input  logic [CNT_W-1:0] cfg_q,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  localparam int unsigned FLD_W = CNT_W - 2;

  // start count field times four: low two bits forced to zero
  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_W-1:0] cfg);
    return {cfg[CNT_W-1:2], 2'b00};
  endfunction

  logic [CNT_W-1:0] reload_v;
  logic             repeat_mode;

  assign reload_v    = reload_of(cfg_q);
  assign repeat_mode = cfg_q[1];
  assign expire      = running && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (cfg_we) begin
      running <= cfg_wval[0];
      if (cfg_wval[0]) count <= reload_of(cfg_wval);
    end else if (expire) begin
      if (repeat_mode) begin
        count <= reload_v;
      end else begin
        count   <= '1;
        running <= 1'b0;
      end
    end else if (running) begin
      count <= count - 1'b1;
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wval[0] |=> running && count == {$past(cfg_wval[CNT_W-1:2]), 2'b00});
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    running && !expire && !cfg_we |=> count == $past(count) - 1'b1);
  a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
    expire && repeat_mode && !cfg_we |=> running && count == $past(reload_v));
  a_r6_park: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !repeat_mode && !cfg_we |=> !running && (&count));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cfg_we |=> $stable(count) && !expire);

  logic [FLD_W-1:0] unused_fld;
  assign unused_fld = cfg_q[CNT_W-1:2];
endmodule

// File: rtl/ctimer_pend.sv
module ctimer_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (set_ev) pend <= 1'b1;
    else if (clr_ev) pend <= 1'b0;
  end

  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> pend);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev && !set_ev |=> !pend);
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ev && pend |=> pend);
endmodule

// File: rtl/ctimer_stamp.sv
module ctimer_stamp #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp <= '0;
    else        stamp <= stamp + 1'b1;
  end

  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> stamp == $past(stamp) + 1'b1);
endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned IRQ_BIT = IRQ_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              timer_irq
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  function automatic logic [DATA_W-1:0] at_bit(input logic b);
    logic [DATA_W-1:0] v;
    v = '0;
    v[IRQ_BIT] = b;
    return v;
  endfunction

  reg_sel_e         sel;
  logic             cfg_we, mask_we, clr_ev;
  logic [CNT_W-1:0] cfg_q, count;
  logic             mask_q, running, expire, pend;
  logic [DATA_W-1:0] stamp;

  ctimer_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(reg_addr), .sel(sel));

  assign cfg_we  = reg_wr && (sel == SEL_CFG);
  assign mask_we = reg_wr && (sel == SEL_MASK);
  assign clr_ev  = reg_wr && (sel == SEL_ACK) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (cfg_we)  cfg_q  <= reg_wdata[CNT_W-1:0];
      if (mask_we) mask_q <= reg_wdata[IRQ_BIT];
    end
  end

  ctimer_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wval(reg_wdata[CNT_W-1:0]),
    .cfg_q(cfg_q), .count(count), .running(running), .expire(expire)
  );

  ctimer_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_ev(expire), .clr_ev(clr_ev), .pend(pend)
  );

  ctimer_stamp #(.DATA_W(DATA_W)) u_stamp (.clk(clk), .rst_n(rst_n), .stamp(stamp));

  assign timer_irq = pend && mask_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_CFG:   reg_rdata = {{PAD_W{1'b0}}, cfg_q};
        SEL_LIVE:  reg_rdata = {{PAD_W{1'b0}}, count};
        SEL_MASK:  reg_rdata = at_bit(mask_q);
        SEL_STAT:  reg_rdata = at_bit(pend);
        SEL_STAMP: reg_rdata = stamp;
        default:   reg_rdata = '0;
      endcase
    end
  end

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> u_pend.pend && mask_q);
  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_irq) |-> $past(expire) || $past(mask_we));
endmodule

// File: tb/test_ctimer_top.sv
module test_ctimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        timer_irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [63:0] q_exp[$];
  string       q_tag[$];

  localparam logic [13:0] CFG = 14'h041, LIVE = 14'h042, ACK = 14'h044,
                          MASK = 14'h004, STAT = 14'h005, STAMP = 14'h048;
  localparam logic [63:0] PEND = 64'h800, PARK = 64'h0000_FFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  ctimer_top i_ctimer_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_irq(timer_irq)
  );

  task automatic note(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard while a read is on the port
  always @(negedge clk) begin
    if (reg_rd && q_exp.size() > 0) begin
      logic [63:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      note(reg_rdata === e, t, reg_rdata, e);
    end
  end

  task automatic op(input logic w, input logic r, input logic [13:0] a, input logic [63:0] d);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask
  task automatic wr(input logic [13:0] a, input logic [63:0] d); op(1'b1, 1'b0, a, d); endtask
  task automatic rd(input logic [13:0] a, input logic [63:0] e, input string tag);
    q_exp.push_back(e); q_tag.push_back(tag);
    op(1'b0, 1'b1, a, '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, '0);
  endtask
  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    note(timer_irq === e, tag, {63'd0, timer_irq}, {63'd0, e});
    @(posedge clk); #1;
  endtask
  task automatic rd_get(input logic [13:0] a, output logic [63:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
    @(posedge clk); #1; reg_rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] s1, s2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(CFG, 0, "R1 cfg");
    rd(LIVE, 0, "R1 live");
    rd(STAT, 0, "R1 status");
    chk_irq(1'b0, "R1 irq");
    wr(MASK, PEND);
    rd(MASK, PEND, "R12 mask readback");
    chk_irq(1'b0, "R9 no event");
    // single shot, start field 10 -> count 40
    wr(CFG, 64'h29);
    rd(CFG, 64'h29, "R2 cfg readback");
    rd(LIVE, 39, "R2 loaded count");
    idle(5);
    rd(LIVE, 33, "R3 decrement");
    idle(32);
    rd(LIVE, 0, "R4 zero cycle");
    rd(STAT, PEND, "R4 event after zero");
    chk_irq(1'b1, "R9 masked on");
    rd(LIVE, PARK, "R6 parked");
    idle(60);
    rd(LIVE, PARK, "R6 stays parked");
    wr(ACK, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(STAT, PEND, "R8 bit0 zero ignored");
    wr(ACK, 64'h1);
    rd(STAT, 0, "R8 cleared");
    chk_irq(1'b0, "R9 cleared");
    idle(50);
    rd(STAT, 0, "R6 no second event");
    rd(ACK, 0, "R10 clear reads zero");
    // repeat mode, count 8, period 9
    wr(MASK, 0);
    wr(CFG, 64'h0B);
    idle(9);
    rd(STAT, PEND, "R5 first event");
    chk_irq(1'b0, "R9 mask off");
    rd(LIVE, 6, "R5 refilled");
    wr(ACK, 64'h1);
    rd(STAT, 0, "R8 clear in repeat");
    idle(4);
    rd(STAT, PEND, "R5 second event");
    idle(7);
    wr(ACK, 64'h1);
    rd(STAT, PEND, "R8 set wins");
    wr(MASK, PEND);
    chk_irq(1'b1, "R9 mask on");
    wr(CFG, 64'h0);
    rd(LIVE, 5, "R7 held");
    wr(ACK, 64'h1);
    idle(30);
    rd(STAT, 0, "R7 no expiry");
    rd(LIVE, 5, "R7 still held");
    wr(14'h043, '1);
    wr(STAT, PEND);
    rd(STAT, 0, "R10 status write ignored");
    rd(14'h043, 0, "R10 unmapped read");
    rd(CFG, 0, "R10 cfg untouched");
    rd(MASK, PEND, "R10 mask untouched");
    wr(CFG, 64'hABCD_0000_0000_0010);
    rd(CFG, 64'h10, "R2 high bits dropped");
    rd(LIVE, 5, "R2 no load without run");
    rd_get(STAMP, s1);
    idle(10);
    rd_get(STAMP, s2);
    note(s2 - s1 == 64'd11, "R11 stamp advance", s2 - s1, 64'd11);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule